// File: doc/BRIEF.md
# Cascadable Synchronous Nibble Counter with Divide-by-Twelve

This block is a chain of 4-bit synchronous binary counter stages on one clock. Each stage has two enables. The count enable (P) is shared by every stage. The carry enable (T) of each stage is fed by the ripple-carry of the stage below it. Stage 0 takes the external T, so the nibble at the bottom of the chain is the only one where the two enables come from the outside. A stage advances only when both of its enables are high. Its ripple-carry is the AND of its four bits and its T input. As a result, the whole chain steps as one wide counter, and every bit changes on the same edge. A synchronous clear and a parallel load act on the whole chain.

Beside the chain sits a 4-bit divide-by-twelve unit. It advances on the same enabled clocks and has two selectable methods. In clear mode it counts 0 to 11 and then clears to 0. In preload mode it counts 4 to 15, and its own ripple-carry reloads it to 4. Once per twelve enabled clocks the unit produces a one-clock divided pulse.

Top module: `casc_counter_top`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, `div_pulse` becomes 0, and `div_count` becomes the start value of the selected mode (0 in clear mode, 4 in preload mode).
- R2: `clr` acts on the next edge. It has priority over `load` and the enables, and sets `count` to 0.
- R3: When `load` is high and `clr` is low, `count` takes `load_data` on the next edge, whatever the state of `en_p` and `en_t`.
- R4: Without clear or load, `count` increments by one only at edges where `en_p` and `en_t` are both high. Otherwise it holds.
- R5: `carry_out` is high exactly when every bit of `count` is 1 and `en_t` is high.
- R6: Stage k (k > 0) receives the ripple-carry of stage k-1 as its T input. `count` is the concatenation of the stages, with stage 0 as bits [3:0], and it behaves as one binary counter modulo 2^(4*STAGES). This includes the wrap from all ones to 0.
- R7: A carry across several nibbles (for example 0x0FF to 0x100) completes in a single clock edge.
- R8: With `div_mode` = 0 (clear mode), `div_count` runs 0,1,…,11 over enabled clocks and then returns to 0.
- R9: With `div_mode` = 1 (preload mode), `div_count` runs 4,5,…,15 over enabled clocks and then is reloaded to 4.
- R10: `div_pulse` is high for exactly one clock: the clock after an enabled edge at which the divider wrapped (11 in clear mode, 15 in preload mode). It is therefore high once per twelve enabled clocks.
- R11: The divider advances only when `en_p` and `en_t` are both high. `clr` restarts it at the mode's start value and clears `div_pulse`. `load` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of chain and divider |
| load | input | 1 | Synchronous parallel load of the chain |
| load_data | input | 4*STAGES | Parallel load value |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Carry enable into stage 0 |
| div_mode | input | 1 | Divider method: 0 clear at terminal, 1 preload |
| count | output | 4*STAGES | Full count, stage 0 least significant |
| carry_out | output | 1 | Ripple-carry of the top stage |
| div_count | output | 4 | Divider state |
| div_pulse | output | 1 | One-clock divided output pulse |

## Verification
Two events can fall on the same edge. One is the divider's terminal wrap or a chain-wide carry. The other is a `clr` or `load` request. The bench makes them coincide in two ways. It asserts `clr` together with `load` and both enables. It also issues loads while the divider is at its terminal value, in both modes. The reference model then decides the outcome from the stated priorities, so that clear wins, load leaves the divider alone, and the wrap pulse is suppressed on a clear. A randomized stretch then mixes all controls against the same model on every clock.

// File: rtl/nibctr_pkg.sv
package nibctr_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  typedef enum logic {
    DIV_CLR = 1'b0,
    DIV_PRE = 1'b1
  } div_mode_e;
endpackage

// File: rtl/nib_stage.sv
module nib_stage
  import nibctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  input  nib_t din,
  input  logic en_p,
  input  logic en_t,
  output nib_t q,
  output logic rco
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (en_p && en_t) begin
      q <= q + nib_t'(1);
    end
  end

  assign rco = (&q) & en_t;

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> (q == $past(din)));
  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && en_p && en_t) |=> (q == $past(q) + nib_t'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/nib_chain.sv
module nib_chain
  import nibctr_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      load,
  input  logic [STAGES*NIB_W-1:0]   din,
  input  logic                      en_p,
  input  logic                      en_t,
  output logic [STAGES*NIB_W-1:0]   count,
  output logic                      carry_out
);

  localparam int CW = STAGES * NIB_W;

  logic [STAGES:0] t_link;
  nib_t            stg_q [STAGES];

  assign t_link[0] = en_t;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    nib_stage u_stg (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .load (load),
      .din  (din[g*NIB_W +: NIB_W]),
      .en_p (en_p),
      .en_t (t_link[g]),
      .q    (stg_q[g]),
      .rco  (t_link[g+1])
    );
    assign count[g*NIB_W +: NIB_W] = stg_q[g];
  end

  assign carry_out = t_link[STAGES];

  // whole chain behaves as one wide counter, carries settle in one edge
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load) |=> (count == $past(count) + CW'($past(en_p && en_t))));
  p_carry_r5: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (en_t && (count == {CW{1'b1}})));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && en_p && carry_out) |=> (count == '0));

endmodule

// File: rtl/div12_unit.sv
module div12_unit
  import nibctr_pkg::*;
#(
  parameter int DIV_LEN = 12
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      en_p,
  input  logic      en_t,
  input  div_mode_e mode,
  output nib_t      div_q,
  output logic      pulse
);

  localparam int   SPAN      = 1 << NIB_W;
  localparam nib_t START_PRE = nib_t'(SPAN - DIV_LEN);
  localparam nib_t TERM_CLR  = nib_t'(DIV_LEN - 1);

  logic pre, en, restart, rco, wrap_clr, wrap_pre, stg_clr, stg_load;

  assign pre      = (mode == DIV_PRE);
  assign en       = en_p & en_t;
  assign restart  = rst | clr;
  assign wrap_clr = en & ~pre & (div_q == TERM_CLR);
  assign wrap_pre = pre & en_p & rco;
  assign stg_clr  = (restart & ~pre) | (~restart & wrap_clr);
  assign stg_load = (restart & pre)  | (~restart & wrap_pre);

  nib_stage u_div_stg (
    .clk  (clk),
    .rst  (1'b0),
    .clr  (stg_clr),
    .load (stg_load),
    .din  (START_PRE),
    .en_p (en_p),
    .en_t (en_t),
    .q    (div_q),
    .rco  (rco)
  );

  always_ff @(posedge clk) begin
    if (restart) begin
      pulse <= 1'b0;
    end else begin
      pulse <= wrap_clr | wrap_pre;
    end
  end

  p_wrap_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && !pre && div_q == TERM_CLR) |=> (div_q == '0));
  p_wrap_pre_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && pre && div_q == nib_t'(SPAN - 1)) |=> (div_q == START_PRE));
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(en));
  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div_q == ($past(pre) ? START_PRE : nib_t'(0))));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(div_q));

endmodule

// File: rtl/casc_counter_top.sv
module casc_counter_top
  import nibctr_pkg::*;
#(
  parameter int STAGES  = 3,
  parameter int DIV_LEN = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    load,
  input  logic [STAGES*4-1:0]     load_data,
  input  logic                    en_p,
  input  logic                    en_t,
  input  logic                    div_mode,
  output logic [STAGES*4-1:0]     count,
  output logic                    carry_out,
  output logic [3:0]              div_count,
  output logic                    div_pulse
);

  localparam int CW = STAGES * NIB_W;

  logic [CW-1:0] chain_q;
  nib_t          div_q;
  div_mode_e     mode_sel;

  assign mode_sel = div_mode_e'(div_mode);

  nib_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .load      (load),
    .din       (load_data),
    .en_p      (en_p),
    .en_t      (en_t),
    .count     (chain_q),
    .carry_out (carry_out)
  );

  div12_unit #(.DIV_LEN(DIV_LEN)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .en_p  (en_p),
    .en_t  (en_t),
    .mode  (mode_sel),
    .div_q (div_q),
    .pulse (div_pulse)
  );

  assign count     = chain_q;
  assign div_count = div_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && !div_pulse));

endmodule

// File: tb/casc_counter_top_tb.sv
module casc_counter_top_tb;
  localparam int STAGES = 3;
  localparam int CW     = STAGES * 4;
  localparam int MODV   = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          load = 1'b0;
  logic [CW-1:0] load_data = '0;
  logic          en_p = 1'b0;
  logic          en_t = 1'b0;
  logic          div_mode = 1'b0;
  logic [CW-1:0] count;
  logic          carry_out;
  logic [3:0]    div_count;
  logic          div_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int ref_cnt = 0;
  int ref_div = 0;
  bit ref_pulse = 0;

  always #10 clk = ~clk;

  casc_counter_top #(.STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .load_data(load_data),
    .en_p(en_p), .en_t(en_t), .div_mode(div_mode),
    .count(count), .carry_out(carry_out), .div_count(div_count), .div_pulse(div_pulse)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare model state, then advance model
  task automatic step(input string rc, input string rd, input bit r, input bit c, input bit l,
                      input int d, input bit p, input bit t, input bit m);
    int st, tm;
    bit en;
    @(negedge clk);
    rst = r; clr = c; load = l; load_data = CW'(d); en_p = p; en_t = t; div_mode = m;
    #1;
    chk(rc, "count", 32'(count), 32'(ref_cnt));
    chk("R5", "carry_out", 32'(carry_out), 32'(t && ref_cnt == MODV - 1));
    chk(rd, "div_count", 32'(div_count), 32'(ref_div));
    chk("R10", "div_pulse", 32'(div_pulse), 32'(ref_pulse));
    en = p && t;
    st = m ? 4 : 0;
    tm = m ? 15 : 11;
    if (r || c) ref_cnt = 0;
    else if (l) ref_cnt = d % MODV;
    else if (en) ref_cnt = (ref_cnt + 1) % MODV;
    if (r || c) begin
      ref_div = st; ref_pulse = 0;
    end else begin
      ref_pulse = en && (ref_div == tm);
      if (en) ref_div = (ref_div == tm) ? st : ((ref_div + 1) % 16);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    ref_cnt = 0; ref_div = 0; ref_pulse = 0;
    // R1: reset state
    step("R1", "R1", 1, 0, 0, 0, 1, 1, 0);
    // R4 / R8 / R10: free counting in clear mode
    for (int i = 0; i < 40; i++) step("R4", "R8", 0, 0, 0, 0, 1, 1, 0);
    // R4 / R11: one enable low at a time
    for (int i = 0; i < 8; i++) step("R4", "R11", 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) step("R4", "R11", 0, 0, 0, 0, 0, 1, 0);
    // R3: load with enables low, divider untouched (R11)
    step("R3", "R11", 0, 0, 1, 'h0FE, 0, 0, 0);
    // R7: multi-nibble carry in one edge
    for (int i = 0; i < 4; i++) step("R7", "R8", 0, 0, 0, 0, 1, 1, 0);
    // R6: wrap from all ones across every stage
    step("R3", "R11", 0, 0, 1, MODV - 3, 1, 1, 0);
    for (int i = 0; i < 6; i++) step("R6", "R8", 0, 0, 0, 0, 1, 1, 0);
    // R5: carry_out gated by en_t at all ones
    step("R3", "R11", 0, 0, 1, MODV - 1, 0, 0, 0);
    step("R5", "R11", 0, 0, 0, 0, 1, 0, 0);
    step("R5", "R11", 0, 0, 0, 0, 0, 1, 0);
    step("R6", "R8", 0, 0, 0, 0, 1, 1, 0);
    // R2: clear beats load and enables
    step("R2", "R11", 0, 1, 1, 'h555, 1, 1, 0);
    step("R2", "R11", 0, 0, 0, 0, 0, 0, 0);
    // reach divider terminal, then load on the wrap edge (R11)
    for (int i = 0; i < 11; i++) step("R4", "R8", 0, 0, 0, 0, 1, 1, 0);
    step("R3", "R11", 0, 0, 1, 'h123, 1, 1, 0);
    step("R3", "R10", 0, 0, 0, 0, 0, 0, 0);
    // R9: preload mode after clear
    step("R2", "R9", 0, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 30; i++) step("R4", "R9", 0, 0, 0, 0, 1, 1, 1);
    // clear at preload terminal suppresses pulse (R11)
    while (ref_div != 15) step("R4", "R9", 0, 0, 0, 0, 1, 1, 1);
    step("R2", "R11", 0, 1, 0, 0, 1, 1, 1);
    step("R2", "R11", 0, 0, 0, 0, 0, 0, 1);
    // R1 in preload mode
    step("R1", "R1", 1, 0, 0, 0, 1, 1, 1);
    step("R1", "R1", 0, 0, 0, 0, 0, 0, 1);
    // randomized mix, mode changes only with clear
    for (int blk = 0; blk < 2; blk++) begin
      bit m = (blk == 0) ? 1'b1 : 1'b0;
      step("R2", "R11", 0, 1, 0, 0, 0, 0, m);
      for (int i = 0; i < 400; i++) begin
        int rv = int'($urandom % 100);
        step("R6", m ? "R9" : "R8", 0, rv < 2, rv >= 2 && rv < 5, int'($urandom % MODV),
             ($urandom % 8) != 0, ($urandom % 8) != 0, m);
      end
    end
    // wide counter over a long enabled run to cross nibble boundaries (R6)
    step("R3", "R11", 0, 0, 1, 'hEF0, 0, 0, 0);
    for (int i = 0; i < 300; i++) step("R6", "R8", 0, 0, 0, 0, 1, 1, 0);
    step("R6", "R8", 0, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule